// File: doc/BRIEF.md
# Line-Synchronous DC-Link Voltage Regulator

This block holds the average voltage of a compensator's DC-link capacitor at a setpoint without a ripple filter. The link voltage carries a ripple at twice the line frequency (six times in three-phase systems), and that ripple always has the same value at the instant the utility voltage crosses zero going positive. The block therefore takes the link-voltage error only at that instant. It passes the error through a fixed-point proportional-integral law and produces a current-amplitude word. The word is held constant for the whole of the next line cycle, so the sine reference generators downstream never see intra-cycle amplitude changes.

The utility polarity arrives as one sign bit per phase. A select input names the phase whose positive crossing is the sampling instant for all phases. The sign bit is debounced with a run-length rule before a crossing is accepted. Gains and output limits are run-time inputs. The integral gain is supplied already multiplied by the line period, because the law runs once per cycle. One amplitude word serves all phases.

Top module: `zc_sampled_pi_reg`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `amp_o` is 0 and `amp_valid_o` is 0. The integrator state is cleared.
- R2: A sign bit of 1 means negative. A crossing is accepted only after the selected sign bit has been 1 for at least DEB consecutive clocks and then 0 for DEB consecutive clocks. The crossing is recognised at the DEB-th such 0 sample. Shorter runs of either level are ignored. Detection starts in the positive state after reset.
- R3: The error `vset - vdc` is taken only on the clock after a recognised crossing. Values of `vdc` at any other time have no effect on `amp_o`.
- R4: `amp_o` changes only on the clock edge one cycle after a crossing is recognised, which is the (DEB+1)-th positive sample. It holds its value until the next such edge.
- R5: `amp_valid_o` is 1 for exactly the one cycle following each amplitude update and 0 otherwise.
- R6: Each update computes `e = vset - vdc` and `I' = I + ki*e` (limited per R8). It then computes `u = floor((kp*e + I') / 2^FRAC)` and sets `amp_o = min(max(u, amin), amax)`. Gains are unsigned with FRAC fraction bits (FRAC = 8 by default).
- R7: Anti-windup: if the amplitude before an update equals `amax` and `e > 0`, or equals `amin` and `e < 0`, the integrator keeps its previous value for that update.
- R8: The integrator is limited to the range `amin*2^FRAC` to `amax*2^FRAC`. The upper limit is applied first.
- R9: Only the phase chosen by `ref_sel` (phase 0 if `ref_sel >= NPH`) can produce a crossing. Sign activity on the other phases has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| v_neg | input | NPH | Per-phase utility sign, 1 = negative |
| ref_sel | input | SELW | Index of the phase used for sampling |
| vdc | input | VW | Digitised DC-link voltage |
| vset | input | VW | Link-voltage setpoint |
| kp | input | GW | Proportional gain, FRAC fraction bits |
| ki | input | GW | Integral gain times line period, FRAC fraction bits |
| amin | input | AW | Lower amplitude and integrator limit |
| amax | input | AW | Upper amplitude and integrator limit |
| amp_o | output | AW | Current-reference amplitude, held per line cycle |
| amp_valid_o | output | 1 | One-cycle strobe when a new amplitude is latched |

## Verification
The embedded properties check these rules on every cycle: the amplitude stays put between strobes, the strobe follows a detector pulse and never lasts two cycles, a crossing pulse always follows a positive sample, and the amplitude and integrator stay inside the limits. They also check that the integrator freezes whenever the anti-windup condition holds at a sample. Only the bench scenarios can show the debounce run lengths and the exact update cycle. The same holds for the arithmetic of the control law, rejection of `vdc` changes between crossings, phase selection, and recovery after saturation. The bench tracks these with its own line-by-line model.

// File: rtl/zcpi_pkg.sv
package zcpi_pkg;
  typedef logic signed [63:0] acc_t;

  function automatic acc_t clamp_acc(input acc_t x, input acc_t lo, input acc_t hi);
    acc_t r;
    if (x > hi)      r = hi;
    else if (x < lo) r = lo;
    else             r = x;
    return r;
  endfunction
endpackage

// File: rtl/zc_detect.sv
module zc_detect #(
  parameter int DEB = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic neg_i,
  output logic zc_o
);
  localparam int CW = $clog2(DEB + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB - 1);

  logic          level_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      run_q   <= '0;
      zc_o    <= 1'b0;
    end else begin
      zc_o <= 1'b0;
      if (neg_i == level_q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        level_q <= neg_i;
        run_q   <= '0;
        zc_o    <= level_q & ~neg_i;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R2: an accepted crossing is always preceded by a positive sample
  p_zc_after_pos_r2: assert property (@(posedge clk) disable iff (rst)
    zc_o |-> !$past(neg_i));
  // R2: a crossing pulse lasts one cycle
  p_zc_single_r2: assert property (@(posedge clk) disable iff (rst)
    zc_o |=> !zc_o);
endmodule

// File: rtl/pi_core.sv
module pi_core #(
  parameter int VW   = 12,
  parameter int GW   = 16,
  parameter int AW   = 12,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_i,
  input  logic [VW-1:0] vdc_i,
  input  logic [VW-1:0] vset_i,
  input  logic [GW-1:0] kp_i,
  input  logic [GW-1:0] ki_i,
  input  logic [AW-1:0] amin_i,
  input  logic [AW-1:0] amax_i,
  output logic [AW-1:0] amp_o,
  output logic          valid_o
);
  import zcpi_pkg::*;

  acc_t integ_q;
  acc_t err, kpx, kix, lo_a, hi_a, lo_i, hi_i;
  acc_t i_sum, i_lim, i_next, u, amp_w;
  logic freeze;

  always_comb begin
    err    = acc_t'(vset_i) - acc_t'(vdc_i);
    kpx    = acc_t'(kp_i);
    kix    = acc_t'(ki_i);
    lo_a   = acc_t'(amin_i);
    hi_a   = acc_t'(amax_i);
    lo_i   = lo_a <<< FRAC;
    hi_i   = hi_a <<< FRAC;
    i_sum  = integ_q + kix * err;
    i_lim  = clamp_acc(i_sum, lo_i, hi_i);
    freeze = ((amp_o == amax_i) && (err > 0)) || ((amp_o == amin_i) && (err < 0));
    i_next = freeze ? integ_q : i_lim;
    u      = (kpx * err + i_next) >>> FRAC;
    amp_w  = clamp_acc(u, lo_a, hi_a);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_o   <= '0;
      integ_q <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= sample_i;
      if (sample_i) begin
        amp_o   <= amp_w[AW-1:0];
        integ_q <= i_next;
      end
    end
  end

  // R4: amplitude holds unless a crossing strobe was present
  p_amp_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !sample_i |=> $stable(amp_o));
  // R5: the strobe only follows a crossing pulse
  p_valid_src_r5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(sample_i));
  // R6: a fresh amplitude lies within stable limits
  p_amp_range_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $stable(amin_i) && $stable(amax_i) && amin_i <= amax_i)
      |-> (amp_o >= amin_i && amp_o <= amax_i));
  // R7: integrator frozen while pushing into a saturated limit
  p_windup_r7: assert property (@(posedge clk) disable iff (rst)
    (sample_i && (((amp_o == amax_i) && (err > 0)) || ((amp_o == amin_i) && (err < 0))))
      |=> $stable(integ_q));
  // R8: integrator stays inside its scaled limits
  p_integ_range_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $stable(amin_i) && $stable(amax_i) && amin_i <= amax_i)
      |-> (integ_q >= lo_i && integ_q <= hi_i));
endmodule

// File: rtl/zc_sampled_pi_reg.sv
module zc_sampled_pi_reg #(
  parameter int NPH  = 3,
  parameter int DEB  = 4,
  parameter int VW   = 12,
  parameter int GW   = 16,
  parameter int AW   = 12,
  parameter int FRAC = 8,
  localparam int SELW = (NPH > 1) ? $clog2(NPH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPH-1:0]  v_neg,
  input  logic [SELW-1:0] ref_sel,
  input  logic [VW-1:0]   vdc,
  input  logic [VW-1:0]   vset,
  input  logic [GW-1:0]   kp,
  input  logic [GW-1:0]   ki,
  input  logic [AW-1:0]   amin,
  input  logic [AW-1:0]   amax,
  output logic [AW-1:0]   amp_o,
  output logic            amp_valid_o
);
  logic sel_neg;
  logic zc_pulse;

  always_comb begin
    if ({1'b0, ref_sel} < (SELW + 1)'(NPH)) sel_neg = v_neg[ref_sel];
    else                                    sel_neg = v_neg[0];
  end

  zc_detect #(.DEB(DEB)) u_zc (
    .clk  (clk),
    .rst  (rst),
    .neg_i(sel_neg),
    .zc_o (zc_pulse)
  );

  pi_core #(.VW(VW), .GW(GW), .AW(AW), .FRAC(FRAC)) u_pi (
    .clk     (clk),
    .rst     (rst),
    .sample_i(zc_pulse),
    .vdc_i   (vdc),
    .vset_i  (vset),
    .kp_i    (kp),
    .ki_i    (ki),
    .amin_i  (amin),
    .amax_i  (amax),
    .amp_o   (amp_o),
    .valid_o (amp_valid_o)
  );

  // R5: strobes never come back to back
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    amp_valid_o |=> !amp_valid_o);
endmodule

// File: tb/zc_sampled_pi_reg_tb.sv
module zc_sampled_pi_reg_tb;
  localparam int NPH = 3, DEB = 4, VW = 12, GW = 16, AW = 12, FRAC = 8, SELW = 2;

  logic clk = 0;
  logic rst;
  logic [NPH-1:0]  v_neg;
  logic [SELW-1:0] ref_sel;
  logic [VW-1:0]   vdc, vset;
  logic [GW-1:0]   kp, ki;
  logic [AW-1:0]   amin, amax;
  logic [AW-1:0]   amp_o;
  logic            amp_valid_o;

  always #10 clk = ~clk;

  zc_sampled_pi_reg #(.NPH(NPH), .DEB(DEB), .VW(VW), .GW(GW), .AW(AW), .FRAC(FRAC)) u_dut (
    .clk(clk), .rst(rst), .v_neg(v_neg), .ref_sel(ref_sel), .vdc(vdc), .vset(vset),
    .kp(kp), .ki(ki), .amin(amin), .amax(amax), .amp_o(amp_o), .amp_valid_o(amp_valid_o));

  int checks = 0, errors = 0;
  bit done = 0;
  longint integ_m = 0, amp_m = 0;
  bit armed_m = 0, pend_m = 0;
  int sel_m = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint clampl(longint x, longint lo, longint hi);
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  // Control law per R6, R7, R8
  task automatic model_update();
    longint e, isum, inext, u;
    bit fr;
    e     = longint'(vset) - longint'(vdc);
    isum  = clampl(integ_m + longint'(ki) * e, longint'(amin) <<< FRAC, longint'(amax) <<< FRAC);
    fr    = (amp_m == amax && e > 0) || (amp_m == amin && e < 0);
    inext = fr ? integ_m : isum;
    u     = (longint'(kp) * e + inext) >>> FRAC;
    amp_m = clampl(u, longint'(amin), longint'(amax));
    integ_m = inext;
  endtask

  // Drive the selected phase to one level for n clocks; check outputs each cycle
  task automatic run(bit neg, int n, int vdcv);
    for (int i = 1; i <= n; i++) begin
      bit expv;
      @(negedge clk);
      v_neg[sel_m] = neg;
      vdc = VW'(vdcv);
      @(posedge clk);
      #1;
      expv = 0;
      if (neg) begin
        pend_m = 0;
        if (i == DEB) armed_m = 1;
      end else begin
        if (i == DEB && armed_m) begin pend_m = 1; armed_m = 0; end
        else if (i == DEB + 1 && pend_m) begin pend_m = 0; expv = 1; model_update(); end
      end
      chk(amp_valid_o == expv, "R2/R5 strobe", amp_valid_o, expv);
      chk(amp_o == AW'(amp_m), "R4/R6 amplitude", amp_o, amp_m);
    end
  endtask

  // One line cycle: negative half with noisy vdc (R3), positive half with the true value
  task automatic line(int nneg, int npos, int vtrue);
    run(1'b1, nneg, int'($urandom_range(0, 4095)));
    run(1'b0, npos, vtrue);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst = 1; v_neg = '0; ref_sel = 0; vdc = 0; vset = 12'd2000;
    kp = 16'd95; ki = 16'd31; amin = 12'd0; amax = 12'd1500;
    repeat (3) @(posedge clk);
    #1;
    chk(amp_o == 0, "R1 reset amp", amp_o, 0);
    chk(amp_valid_o == 0, "R1 reset strobe", amp_valid_o, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk(amp_o == 0 && amp_valid_o == 0, "R1 after reset", amp_o, 0);

    // R2: short negative run after reset does not arm
    line(DEB - 1, 12, 1900);
    // R2: full negative, short positive glitch, then full line -> one crossing
    run(1'b1, 10, 1950); run(1'b0, DEB - 1, 100); line(10, 12, 1900);
    // R6: several lines below setpoint
    for (int k = 0; k < 4; k++) line(10, 10, 1950 - 20 * k);
    // R3: vdc above setpoint for one line
    line(10, 10, 2100);

    // R9: toggle unselected phase 1 fully, selected stays positive -> no strobe
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < 2 * DEB + 2; j++) begin
        @(negedge clk); v_neg[1] = (j < DEB + 1);
        @(posedge clk); #1;
        chk(amp_valid_o == 0, "R9 other phase ignored", amp_valid_o, 0);
        chk(amp_o == AW'(amp_m), "R9 amp held", amp_o, amp_m);
      end
    end
    @(negedge clk); v_neg = '0;
    // R9: three-phase gains, select phase 2
    ref_sel = 2; sel_m = 2; kp = 16'd36; ki = 16'd23;
    for (int k = 0; k < 3; k++) line(9, 9, 1980);

    // R7/R8: small upper limit, large positive error drives saturation
    amax = 12'd60;
    for (int k = 0; k < 5; k++) line(8, 8, 1000);
    chk(amp_o == 60, "R7 saturated at amax", amp_o, 60);
    // recovery with negative error shows whether the integrator wound up
    for (int k = 0; k < 3; k++) line(8, 8, 2040);
    amax = 12'd1500;

    // random lines, mixed with glitches
    ref_sel = 0; sel_m = 0; kp = 16'd95; ki = 16'd31;
    for (int k = 0; k < 40; k++) begin
      int nn, np;
      nn = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, DEB - 1)) : int'($urandom_range(DEB, 20));
      np = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, DEB - 1)) : int'($urandom_range(DEB + 1, 20));
      line(nn, np, int'($urandom_range(1700, 2300)));
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule